// File: doc/BRIEF.md
# Configuration Port Bridge with Word FIFOs

This block sits between a host register bus and a 32-bit-wide device configuration port. The host pushes configuration words into a 1024-word outbound queue and then issues a drain command. A sequencer presents those words one at a time on a valid/ready output stream until the queue is empty. For readback, the host programs a word count and issues a fetch command. The sequencer then accepts exactly that many words from an inbound valid/ready stream into a 256-word return queue, and the host pops them through a data register.

The host also sees how much space is free in the outbound queue and how many words wait in the return queue. A status word combines the sequencer's completion flag with four pass-through status lines from the port. A small interrupt unit latches rising edges of four queue-level conditions and raises one interrupt line through per-source and global enables. A flush bit empties both queues. A self-clearing soft reset returns the whole block to its defaults.

The sequencer has three states. SEQ_IDLE goes to SEQ_DRAIN on a drain command, or to SEQ_FETCH on a fetch command. SEQ_DRAIN returns to SEQ_IDLE once the outbound queue is found empty. SEQ_FETCH returns to SEQ_IDLE once the remaining count reaches zero. A held flush or a soft reset forces the sequencer to SEQ_IDLE from any state.

Top module: `cfg_port_bridge`

## Requirements
- R1: After hardware reset, or one cycle after a control write with bit 3 set, the registers read as follows: global enable (0x1C) 0, interrupt status (0x20) 0, interrupt enable (0x28) 0, size (0x108) 0, control (0x10C) 0, vacancy (0x114) 1024 and occupancy (0x118) 0. Status (0x110) bit 0 reads 1.
- R2: A bus write to 0x100 appends a word to the outbound queue. The write is dropped when the queue already holds 1024 words. Register 0x114 reads 1024 minus the number of stored words.
- R3: A control write with bit 0 set in SEQ_IDLE enters SEQ_DRAIN. In that state `cp_out_valid` is high while the outbound queue is not empty and `cp_busy` is low, and `cp_out_data` shows the oldest word. Each cycle with valid and ready high consumes one word, in order.
- R4: A control write with bit 1 set in SEQ_IDLE enters SEQ_FETCH with the remaining count taken from the size register. `cp_in_ready` is high while the count is non-zero, the return queue holds fewer than 256 words and `cp_busy` is low. Each accepted word is appended to the return queue and decrements the count. A fetch stalls while the return queue is full and resumes as the host pops words. Register 0x118 reads the number of stored words.
- R5: A bus read of 0x104 returns the oldest return-queue word and removes it. A read of 0x104 while the queue is empty removes nothing, leaves 0x118 at 0, and returns the same value on repeated empty reads.
- R6: Status (0x110) reads as follows: bit 0 is 1 exactly in SEQ_IDLE, bits 1 to 4 are 1, and bits 5, 6, 7 and 8 reflect `cp_abort_n`, `cp_rdbk_act`, `cp_synced` and `cp_cfg_err`. All higher bits read 0.
- R7: Start commands outside SEQ_IDLE are ignored. When bits 0 and 1 are written together, the drain is started. Start bits always read back as 0.
- R8: Control bit 2 is stored and reads back. While it is 1, both queues are emptied at every edge, the sequencer is held in SEQ_IDLE, and host pushes and port transfers are discarded.
- R9: Interrupt status bits are set on a rising edge of their condition: bit 3 return queue full, bit 2 outbound queue empty, bit 1 return queue at least 128 words, bit 0 outbound queue at least 512 words. Writing 1 to a status bit inverts it. A rising edge in the same cycle as a write leaves the bit at 1.
- R10: `irq` is high exactly when bit 31 of 0x1C is 1 and some interrupt status bit is 1 together with its enable bit in 0x28.
- R11: The size register keeps only the low 12 bits of the written value, which limits one fetch to 4095 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the return queue at 0x104) |
| bus_addr | input | 9 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cp_out_valid | output | 1 | Outbound word valid |
| cp_out_data | output | 32 | Outbound word |
| cp_out_ready | input | 1 | Port accepts the outbound word |
| cp_in_valid | input | 1 | Inbound readback word valid |
| cp_in_data | input | 32 | Inbound readback word |
| cp_in_ready | output | 1 | Bridge accepts the inbound word |
| cp_busy | input | 1 | Port busy; blocks both streams |
| cp_abort_n | input | 1 | Port abort flag, active low (status bit 5) |
| cp_rdbk_act | input | 1 | Port readback-in-progress flag (status bit 6) |
| cp_synced | input | 1 | Port sync-aligned flag (status bit 7) |
| cp_cfg_err | input | 1 | Port configuration error flag (status bit 8) |
| irq | output | 1 | Interrupt request |

## Verification
A sequencer stuck in the wrong state shows up on the next clock. `cp_out_valid` or `cp_in_ready` is driven when it should be quiet, or stays low when it should be active, and status bit 0 disagrees at once. A queue pointer or count off by one shows up in two ways. It shows in the vacancy or occupancy value on the very next cycle. It also shows in the first word presented on a stream or popped through 0x104, because the word order no longer matches the order written. A wrong edge register in the interrupt unit shows on `irq` and in the 0x20 readback within one cycle of the queue level crossing.

// File: rtl/cpb_pkg.sv
`timescale 1ns/1ps
package cpb_pkg;

    localparam int ADDR_W = 9;
    localparam int IRQ_N  = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DRAIN = 2'd1,
        SEQ_FETCH = 2'd2
    } seq_state_e;

    // register byte offsets
    localparam logic [ADDR_W-1:0] A_GIE   = 9'h01C;
    localparam logic [ADDR_W-1:0] A_ISR   = 9'h020;
    localparam logic [ADDR_W-1:0] A_IER   = 9'h028;
    localparam logic [ADDR_W-1:0] A_WFIFO = 9'h100;
    localparam logic [ADDR_W-1:0] A_RFIFO = 9'h104;
    localparam logic [ADDR_W-1:0] A_SIZE  = 9'h108;
    localparam logic [ADDR_W-1:0] A_CTRL  = 9'h10C;
    localparam logic [ADDR_W-1:0] A_STAT  = 9'h110;
    localparam logic [ADDR_W-1:0] A_WVAC  = 9'h114;
    localparam logic [ADDR_W-1:0] A_ROCC  = 9'h118;

    // control bit positions
    localparam int CTL_GO_WR = 0;
    localparam int CTL_GO_RD = 1;
    localparam int CTL_FLUSH = 2;
    localparam int CTL_SRST  = 3;

endpackage

// File: rtl/cpb_fifo.sv
`timescale 1ns/1ps
module cpb_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= wdata;
    end

endmodule

// File: rtl/cpb_seq.sv
`timescale 1ns/1ps
module cpb_seq
    import cpb_pkg::*;
#(
    parameter int SZ_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            go_wr,
    input  logic            go_rd,
    input  logic [SZ_W-1:0] size,
    input  logic            wf_empty,
    input  logic            rf_full,
    input  logic            port_busy,
    input  logic            out_ready,
    input  logic            in_valid,
    output logic            done,
    output logic            out_valid,
    output logic            wf_pop,
    output logic            in_ready,
    output logic            rf_push
);

    seq_state_e      state, nxt;
    logic [SZ_W-1:0] remain;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE:  if (go_wr) nxt = SEQ_DRAIN;
                       else if (go_rd) nxt = SEQ_FETCH;
            SEQ_DRAIN: if (wf_empty) nxt = SEQ_IDLE;
            SEQ_FETCH: if (remain == '0) nxt = SEQ_IDLE;
            default:   nxt = SEQ_IDLE;
        endcase
        if (abort) nxt = SEQ_IDLE;
    end

    // state register and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            remain <= '0;
        end else begin
            state <= nxt;
            if (abort)
                remain <= '0;
            else if (state == SEQ_IDLE && !go_wr && go_rd)
                remain <= size;
            else if (rf_push)
                remain <= remain - 1'b1;
        end
    end

    // outputs
    always_comb begin
        done      = (state == SEQ_IDLE);
        out_valid = (state == SEQ_DRAIN) && !wf_empty && !port_busy;
        wf_pop    = out_valid && out_ready;
        in_ready  = (state == SEQ_FETCH) && (remain != '0) && !rf_full && !port_busy;
        rf_push   = in_ready && in_valid;
    end

endmodule

// File: rtl/cpb_irq.sv
`timescale 1ns/1ps
module cpb_irq #(
    parameter int          N         = 4,
    parameter logic [N-1:0] IDLE_COND = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic [N-1:0] cond,
    input  logic         tog_we,
    input  logic [N-1:0] tog,
    input  logic         ier_we,
    input  logic [N-1:0] ier_d,
    input  logic         gie_we,
    input  logic         gie_d,
    output logic [N-1:0] isr,
    output logic [N-1:0] ier,
    output logic         gie,
    output logic         irq
);

    logic [N-1:0] prev;
    logic [N-1:0] flip;

    assign flip = tog_we ? tog : '0;
    assign irq  = gie && |(isr & ier);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr  <= '0;
            ier  <= '0;
            gie  <= 1'b0;
            prev <= IDLE_COND;
        end else if (srst) begin
            isr  <= '0;
            ier  <= '0;
            gie  <= 1'b0;
            prev <= IDLE_COND;
        end else begin
            prev <= cond;
            isr  <= (isr ^ flip) | (cond & ~prev);
            if (ier_we) ier <= ier_d;
            if (gie_we) gie <= gie_d;
        end
    end

endmodule

// File: rtl/cfg_port_bridge.sv
`timescale 1ns/1ps
module cfg_port_bridge
    import cpb_pkg::*;
#(
    parameter int WR_DEPTH = 1024,
    parameter int RD_DEPTH = 256,
    parameter int DATA_W   = 32,
    parameter int SZ_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cp_out_valid,
    output logic [DATA_W-1:0] cp_out_data,
    input  logic              cp_out_ready,
    input  logic              cp_in_valid,
    input  logic [DATA_W-1:0] cp_in_data,
    output logic              cp_in_ready,
    input  logic              cp_busy,
    input  logic              cp_abort_n,
    input  logic              cp_rdbk_act,
    input  logic              cp_synced,
    input  logic              cp_cfg_err,
    output logic              irq
);

    localparam int WCW = $clog2(WR_DEPTH) + 1;
    localparam int RCW = $clog2(RD_DEPTH) + 1;

    logic wr_ctrl, srst, go_wr, go_rd;
    logic flush_q, fifo_clr;
    logic [SZ_W-1:0] size_q;
    logic [WCW-1:0] wf_cnt;
    logic [RCW-1:0] rf_cnt;
    logic wf_full, wf_empty, rf_full, rf_empty;
    logic wf_pop, rf_push, seq_done;
    logic [DATA_W-1:0] rf_head;
    logic [IRQ_N-1:0] cond, isr_q, ier_q;
    logic gie_q;
    logic [DATA_W-2:SZ_W] unused_wdata;

    assign unused_wdata = bus_wdata[DATA_W-2:SZ_W];

    // command decode
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign srst     = wr_ctrl && bus_wdata[CTL_SRST];
    assign go_wr    = wr_ctrl && bus_wdata[CTL_GO_WR] && !srst;
    assign go_rd    = wr_ctrl && bus_wdata[CTL_GO_RD] && !srst;
    assign fifo_clr = srst || flush_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
            size_q  <= '0;
        end else if (srst) begin
            flush_q <= 1'b0;
            size_q  <= '0;
        end else begin
            if (wr_ctrl) flush_q <= bus_wdata[CTL_FLUSH];
            if (bus_wr && bus_addr == A_SIZE) size_q <= bus_wdata[SZ_W-1:0];
        end
    end

    cpb_fifo #(.DEPTH(WR_DEPTH), .W(DATA_W)) u_wfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (bus_wr && bus_addr == A_WFIFO),
        .wdata (bus_wdata),
        .pop   (wf_pop),
        .rdata (cp_out_data),
        .count (wf_cnt),
        .full  (wf_full),
        .empty (wf_empty)
    );

    cpb_fifo #(.DEPTH(RD_DEPTH), .W(DATA_W)) u_rfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (rf_push),
        .wdata (cp_in_data),
        .pop   (bus_rd && bus_addr == A_RFIFO),
        .rdata (rf_head),
        .count (rf_cnt),
        .full  (rf_full),
        .empty (rf_empty)
    );

    cpb_seq #(.SZ_W(SZ_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (fifo_clr),
        .go_wr     (go_wr),
        .go_rd     (go_rd),
        .size      (size_q),
        .wf_empty  (wf_empty),
        .rf_full   (rf_full),
        .port_busy (cp_busy),
        .out_ready (cp_out_ready),
        .in_valid  (cp_in_valid),
        .done      (seq_done),
        .out_valid (cp_out_valid),
        .wf_pop    (wf_pop),
        .in_ready  (cp_in_ready),
        .rf_push   (rf_push)
    );

    // interrupt sources: rf full, wf empty, rf half, wf half
    assign cond = {rf_full,
                   wf_empty,
                   rf_cnt >= RCW'(RD_DEPTH / 2),
                   wf_cnt >= WCW'(WR_DEPTH / 2)};

    cpb_irq #(.N(IRQ_N), .IDLE_COND(4'b0100)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst   (srst),
        .cond   (cond),
        .tog_we (bus_wr && bus_addr == A_ISR),
        .tog    (bus_wdata[IRQ_N-1:0]),
        .ier_we (bus_wr && bus_addr == A_IER),
        .ier_d  (bus_wdata[IRQ_N-1:0]),
        .gie_we (bus_wr && bus_addr == A_GIE),
        .gie_d  (bus_wdata[DATA_W-1]),
        .isr    (isr_q),
        .ier    (ier_q),
        .gie    (gie_q),
        .irq    (irq)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_GIE:   bus_rdata[DATA_W-1]    = gie_q;
            A_ISR:   bus_rdata[IRQ_N-1:0]   = isr_q;
            A_IER:   bus_rdata[IRQ_N-1:0]   = ier_q;
            A_RFIFO: bus_rdata              = rf_head;
            A_SIZE:  bus_rdata[SZ_W-1:0]    = size_q;
            A_CTRL:  bus_rdata[CTL_FLUSH]   = flush_q;
            A_STAT:  bus_rdata[8:0]         = {cp_cfg_err, cp_synced, cp_rdbk_act,
                                               cp_abort_n, 4'hF, seq_done};
            A_WVAC:  bus_rdata[WCW-1:0]     = WCW'(WR_DEPTH) - wf_cnt;
            A_ROCC:  bus_rdata[RCW-1:0]     = rf_cnt;
            default: bus_rdata              = '0;
        endcase
    end

endmodule

// File: rtl/cfg_port_bridge_chk.sv
`timescale 1ns/1ps
module cfg_port_bridge_chk #(
    parameter int WR_DEPTH = 1024,
    parameter int RD_DEPTH = 256,
    localparam int WCW = $clog2(WR_DEPTH) + 1,
    localparam int RCW = $clog2(RD_DEPTH) + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cp_busy,
    input logic           cp_out_valid,
    input logic           cp_out_ready,
    input logic           cp_in_ready,
    input logic           irq,
    input logic           gie,
    input logic           fifo_clr,
    input logic           rf_full,
    input logic [WCW-1:0] wf_cnt,
    input logic [RCW-1:0] rf_cnt
);

    p_wf_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wf_cnt <= WCW'(WR_DEPTH));

    p_wf_keep_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_cnt == WCW'(WR_DEPTH) && !(cp_out_valid && cp_out_ready) && !fifo_clr)
        |=> wf_cnt == WCW'(WR_DEPTH));

    p_busy_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cp_busy |-> (!cp_out_valid && !cp_in_ready));

    p_rf_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_cnt <= RCW'(RD_DEPTH));

    p_rf_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_full |-> !cp_in_ready);

    p_one_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cp_out_valid && cp_in_ready));

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (wf_cnt == '0 && rf_cnt == '0));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(
    .WR_DEPTH (WR_DEPTH),
    .RD_DEPTH (RD_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cp_busy      (cp_busy),
    .cp_out_valid (cp_out_valid),
    .cp_out_ready (cp_out_ready),
    .cp_in_ready  (cp_in_ready),
    .irq          (irq),
    .gie          (gie_q),
    .fifo_clr     (fifo_clr),
    .rf_full      (rf_full),
    .wf_cnt       (wf_cnt),
    .rf_cnt       (rf_cnt)
);

// File: tb/cfg_port_bridge_tb.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb;

    localparam int WR = 1024;
    localparam int RD = 256;

    localparam logic [8:0] GIE = 9'h01C, ISR = 9'h020, IER = 9'h028, WFI = 9'h100,
                           RFI = 9'h104, SIZ = 9'h108, CTL = 9'h10C, STA = 9'h110,
                           WVA = 9'h114, ROC = 9'h118;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, bus_wr, bus_rd, cp_out_valid, cp_out_ready, cp_in_valid, cp_in_ready;
    logic        cp_busy, cp_abort_n, cp_rdbk_act, cp_synced, cp_cfg_err, irq;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, cp_out_data, cp_in_data;

    cfg_port_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cp_out_valid(cp_out_valid),
        .cp_out_data(cp_out_data), .cp_out_ready(cp_out_ready), .cp_in_valid(cp_in_valid),
        .cp_in_data(cp_in_data), .cp_in_ready(cp_in_ready), .cp_busy(cp_busy),
        .cp_abort_n(cp_abort_n), .cp_rdbk_act(cp_rdbk_act), .cp_synced(cp_synced),
        .cp_cfg_err(cp_cfg_err), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] wq[$];
    logic [31:0] rq[$];
    int          mst, mrem;
    logic        m_gie, m_flush;
    logic [3:0]  m_ier, m_isr, m_prev;
    logic [11:0] m_size;

    int n_cmp = 0, n_bad = 0;
    int p_ready = 100, p_valid = 100, p_busy = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int rnd100();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr % 16'd100);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_defaults();
        wq.delete(); rq.delete();
        mst = 0; mrem = 0; m_gie = 0; m_flush = 0;
        m_ier = 0; m_isr = 0; m_prev = 4'b0100; m_size = 0;
    endtask

    function automatic logic m_ov();
        return (mst == 1) && (wq.size() > 0) && !cp_busy;
    endfunction

    function automatic logic m_ir();
        return (mst == 2) && (mrem > 0) && (rq.size() < RD) && !cp_busy;
    endfunction

    function automatic logic [31:0] m_rdata();
        case (bus_addr)
            GIE: return {m_gie, 31'b0};
            ISR: return {28'b0, m_isr};
            IER: return {28'b0, m_ier};
            RFI: return rq[0];
            SIZ: return {20'b0, m_size};
            CTL: return {29'b0, m_flush, 2'b0};
            STA: return {23'b0, cp_cfg_err, cp_synced, cp_rdbk_act, cp_abort_n, 4'hF, mst == 0};
            WVA: return 32'(WR - wq.size());
            ROC: return 32'(rq.size());
            default: return 32'h0;
        endcase
    endfunction

    function automatic string addr_tag();
        case (bus_addr)
            GIE, IER: return "R10 reg";
            ISR:      return "R9 isr";
            RFI:      return "R5 rdata";
            SIZ:      return "R11 size";
            CTL:      return "R8 ctrl";
            STA:      return "R6 status";
            WVA:      return "R2 vacancy";
            ROC:      return "R4 occupancy";
            default:  return "R1 unmapped";
        endcase
    endfunction

    task automatic compare();
        chk("R10 irq", {31'b0, irq}, {31'b0, m_gie && |(m_isr & m_ier)});
        chk("R3 out_valid", {31'b0, cp_out_valid}, {31'b0, m_ov()});
        if (m_ov()) chk("R3 out_data", cp_out_data, wq[0]);
        chk("R4 in_ready", {31'b0, cp_in_ready}, {31'b0, m_ir()});
        if (!(bus_addr == RFI && rq.size() == 0)) chk(addr_tag(), bus_rdata, m_rdata());
    endtask

    task automatic m_update();
        logic [3:0] cnd;
        logic wpop, rpush, hpush, hpop, gw, gr, pre_empty;
        int pre_rem, pre_st;
        if (bus_wr && bus_addr == CTL && bus_wdata[3]) begin
            m_defaults();
            return;
        end
        cnd = {rq.size() == RD, wq.size() == 0, rq.size() >= RD / 2, wq.size() >= WR / 2};
        m_isr = (m_isr ^ ((bus_wr && bus_addr == ISR) ? bus_wdata[3:0] : 4'h0)) | (cnd & ~m_prev);
        m_prev = cnd;
        if (bus_wr && bus_addr == IER) m_ier = bus_wdata[3:0];
        if (bus_wr && bus_addr == GIE) m_gie = bus_wdata[31];
        wpop  = m_ov() && cp_out_ready;
        rpush = m_ir() && cp_in_valid;
        hpush = bus_wr && bus_addr == WFI && wq.size() < WR;
        hpop  = bus_rd && bus_addr == RFI && rq.size() > 0;
        gw = bus_wr && bus_addr == CTL && bus_wdata[0];
        gr = bus_wr && bus_addr == CTL && bus_wdata[1];
        pre_empty = (wq.size() == 0); pre_rem = mrem; pre_st = mst;
        if (m_flush) begin
            wq.delete(); rq.delete(); mst = 0; mrem = 0;
        end else begin
            if (wpop)  void'(wq.pop_front());
            if (hpush) wq.push_back(bus_wdata);
            if (hpop)  void'(rq.pop_front());
            if (rpush) rq.push_back(cp_in_data);
            case (pre_st)
                0: if (gw) mst = 1; else if (gr) begin mst = 2; mrem = int'(m_size); end
                1: if (pre_empty) mst = 0;
                default: if (pre_rem == 0) mst = 0; else if (rpush) mrem--;
            endcase
        end
        if (bus_wr && bus_addr == SIZ) m_size = bus_wdata[11:0];
        if (bus_wr && bus_addr == CTL) m_flush = bus_wdata[2];
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        m_update();
        @(negedge clk);
        cp_out_ready = (rnd100() < p_ready);
        cp_in_valid  = (rnd100() < p_valid);
        cp_busy      = (rnd100() < p_busy);
        void'(rnd100());
        cp_in_data   = {lfsr, ~lfsr};
    endtask

    task automatic reg_wr(logic [8:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(logic [8:0] a);
        bus_rd = 1'b1; bus_addr = a;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(logic [8:0] a, logic [31:0] e, string tag);
        bus_addr = a;
        #0.5 chk(tag, bus_rdata, e);
        step();
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && mst != 0; i++) step();
        step();
    endtask

    task automatic check_defaults(string tag);
        expect_reg(GIE, 32'h0, tag);
        expect_reg(ISR, 32'h0, tag);
        expect_reg(IER, 32'h0, tag);
        expect_reg(SIZ, 32'h0, tag);
        expect_reg(CTL, 32'h0, tag);
        expect_reg(WVA, 32'd1024, tag);
        expect_reg(ROC, 32'd0, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v0;
        rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        cp_out_ready = 0; cp_in_valid = 0; cp_in_data = 0; cp_busy = 0;
        cp_abort_n = 1; cp_rdbk_act = 0; cp_synced = 0; cp_cfg_err = 0;
        m_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        check_defaults("R1 reset");
        expect_reg(STA, 32'h03F, "R1 R6 status after reset");

        // R6 status inputs
        cp_abort_n = 0; cp_cfg_err = 1; cp_synced = 1;
        expect_reg(STA, 32'h19F, "R6 status inputs");
        cp_abort_n = 1; cp_cfg_err = 0; cp_synced = 0; cp_rdbk_act = 1;
        expect_reg(STA, 32'h07F, "R6 status inputs");
        cp_rdbk_act = 0;

        reg_wr(GIE, 32'h8000_0000);
        reg_wr(IER, 32'h0000_000F);

        // R3 simple drain
        for (int i = 0; i < 10; i++) reg_wr(WFI, 32'hA000_0000 + i);
        reg_wr(CTL, 32'h1);
        bus_addr = STA;
        wait_done();

        // R3 drain with backpressure and busy, pushes during drain
        p_ready = 50; p_busy = 20;
        for (int i = 0; i < 5; i++) reg_wr(WFI, 32'hB000_0000 + i);
        reg_wr(CTL, 32'h1);
        for (int i = 0; i < 3; i++) reg_wr(WFI, 32'hB100_0000 + i);
        wait_done();
        p_busy = 0;

        // R7 start while busy ignored
        p_ready = 0;
        for (int i = 0; i < 4; i++) reg_wr(WFI, 32'hC000_0000 + i);
        reg_wr(CTL, 32'h1);
        reg_wr(SIZ, 32'd3);
        reg_wr(CTL, 32'h2);
        step();
        chk("R7 fetch ignored in drain", {31'b0, cp_in_ready}, 32'h0);
        expect_reg(CTL, 32'h0, "R7 start bits read 0");
        p_ready = 100;
        wait_done();
        expect_reg(ROC, 32'd0, "R7 no words fetched");

        // R7 both start bits: drain wins
        p_ready = 0;
        reg_wr(WFI, 32'hD000_0001);
        reg_wr(WFI, 32'hD000_0002);
        reg_wr(CTL, 32'h3);
        #0.5 chk("R7 drain wins", {31'b0, cp_out_valid}, 32'h1);
        p_ready = 100;
        wait_done();

        // R11 size truncation and R4 readback
        reg_wr(SIZ, 32'h0000_1005);
        expect_reg(SIZ, 32'h005, "R11 size low 12 bits");
        p_valid = 60; p_busy = 10;
        reg_wr(CTL, 32'h2);
        wait_done();
        p_busy = 0;
        expect_reg(ROC, 32'd5, "R4 fetched count");
        for (int i = 0; i < 5; i++) reg_rd(RFI);

        // R4 stall on full return queue
        p_valid = 100;
        reg_wr(SIZ, 32'd300);
        reg_wr(CTL, 32'h2);
        repeat (270) step();
        expect_reg(ROC, 32'd256, "R4 stall at full");
        #0.5 chk("R4 R6 done low while stalled", {31'b0, bus_rdata[0] & (bus_addr == STA)}, 32'h0);
        for (int i = 0; i < 300; i++) reg_rd(RFI);
        wait_done();
        for (int i = 0; i < 10; i++) reg_rd(RFI);
        reg_wr(ISR, 32'h0000_000F);
        bus_addr = ISR; step();

        // R2 overflow drops
        for (int i = 0; i < WR + 6; i++) reg_wr(WFI, 32'hE000_0000 + i);
        expect_reg(WVA, 32'd0, "R2 full vacancy");

        // R8 flush
        reg_wr(CTL, 32'h4);
        reg_wr(WFI, 32'hF000_0000);
        step();
        expect_reg(WVA, 32'd1024, "R8 flush empties outbound");
        expect_reg(CTL, 32'h4, "R8 flush bit reads back");
        reg_wr(CTL, 32'h0);
        expect_reg(ROC, 32'd0, "R8 flush empties return");

        // R5 empty reads
        bus_addr = RFI; #0.5 v0 = bus_rdata;
        reg_rd(RFI);
        bus_addr = RFI; #0.5 chk("R5 empty read stable", bus_rdata, v0);
        reg_rd(RFI);
        expect_reg(ROC, 32'd0, "R5 empty read no effect");

        // R1 soft reset
        reg_wr(SIZ, 32'd77);
        reg_wr(WFI, 32'h1234_5678);
        reg_wr(CTL, 32'h8);
        check_defaults("R1 soft reset");

        // R9 / R10 toggle and gating
        reg_wr(IER, 32'h1);
        reg_wr(ISR, 32'h1);
        #0.5 chk("R10 irq gated by global", {31'b0, irq}, 32'h0);
        reg_wr(GIE, 32'h8000_0000);
        #0.5 chk("R10 irq raised", {31'b0, irq}, 32'h1);
        reg_wr(ISR, 32'h1);
        expect_reg(ISR, 32'h0, "R9 toggle clears");
        #0.5 chk("R10 irq dropped", {31'b0, irq}, 32'h0);

        repeat (4) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule